// File: doc/BRIEF.md
# DMA Peripheral Request Router

This block sits between a set of peripherals and a bank of DMA channels that are grouped in pairs. Each pair has a 4-bit selector that names one peripheral. The receive request of that peripheral feeds the even channel of the pair, and its transmit request feeds the odd channel. The acknowledges that the channels return travel back along the same path, to the peripheral line that raised the request. Peripheral request and acknowledge lines are indexed by their selector code. Code 0 is SPI, code 2 is the first UART, code 3 is the second UART, code 4 is I2C and code 5 is the ADC. The ADC is receive-only. Code 1 and codes 6 to 14 are reserved, and code 15 means no peripheral.

Two pairs may name the same peripheral. In that case both pairs see its requests, but only the lowest-numbered of those pairs may acknowledge it. The block also keeps one interrupt status bit per channel. A channel's set pulse raises its bit. A clear write with a 1 in a bit position lowers that bit. Software reaches the selectors and the clear strobe through a register bus, which is outside this block.

Top module: `dma_req_router`

## Requirements
- R1: When the selector of pair p (bits 4p+3..4p of `pair_sel`) holds a routable code c (0, 2, 3, 4 or 5), `ch_req[2p]` equals `periph_rx_req[c]` in the same cycle.
- R2: For codes 0, 2, 3 and 4, `ch_req[2p+1]` equals `periph_tx_req[c]` in the same cycle.
- R3: For code 5 (ADC), `ch_req[2p+1]` stays 0 whatever `periph_tx_req` holds.
- R4: For code 1, codes 6 to 14 and code 15, both request outputs of the pair are 0, and that pair's acknowledges reach no peripheral.
- R5: When pair p alone owns peripheral c, `periph_rx_ack[c]` equals `ch_ack[2p]` and `periph_tx_ack[c]` equals `ch_ack[2p+1]`. Every other acknowledge output is 0.
- R6: When several pairs select the same routable code, only the lowest-numbered of them drives that peripheral's acknowledges. The acknowledges of the higher pairs are dropped.
- R7: `periph_tx_ack[5]` is always 0.
- R8: After reset `irq_status` is 0, and a 1 on `irq_set[i]` makes `irq_status[i]` 1 after the next rising clock edge.
- R9: A cycle with `irq_clr_we` high and `irq_clr_data[i]` = 1 clears `irq_status[i]` at the next edge. A 0 in `irq_clr_data[i]` leaves the bit unchanged.
- R10: When a set pulse and a clear hit the same bit in the same cycle, the bit ends up 1.
- R11: With no set and no clear on a bit, `irq_status[i]` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_sel | input | NUM_PAIRS*SEL_W | Selector of pair p in bits SEL_W*p+SEL_W-1 down to SEL_W*p |
| periph_rx_req | input | NUM_SLOTS | Receive requests, indexed by selector code |
| periph_tx_req | input | NUM_SLOTS | Transmit requests, indexed by selector code |
| ch_req | output | 2*NUM_PAIRS | Channel requests; even channel receive, odd channel transmit |
| ch_ack | input | 2*NUM_PAIRS | Channel acknowledges |
| periph_rx_ack | output | NUM_SLOTS | Receive acknowledges, indexed by selector code |
| periph_tx_ack | output | NUM_SLOTS | Transmit acknowledges, indexed by selector code |
| irq_set | input | 2*NUM_PAIRS | Per-channel interrupt set pulses |
| irq_clr_we | input | 1 | Clear-register write strobe |
| irq_clr_data | input | 2*NUM_PAIRS | Clear mask; a 1 clears the matching status bit |
| irq_status | output | 2*NUM_PAIRS | Per-channel interrupt status |

## Verification
The bench builds the router with its defaults: two pairs (four channels), 4-bit selectors and six peripheral slots. With these values it can sweep all sixteen selector codes on both pairs. Because exactly two pairs exist, it can also set up each case where both pairs name the same peripheral and decide the acknowledge owner.

// File: rtl/dma_route_pkg.sv
package dma_route_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned SLOTS     = 6;
  localparam int unsigned ADC_CODE  = 5;
  localparam int unsigned RSVD_CODE = 1;

  // A code routes when it names an existing, non-reserved slot.
  function automatic logic code_routes(input int unsigned code,
                                       input int unsigned nslots,
                                       input int unsigned rsvd);
    return (code < nslots) && (code != rsvd);
  endfunction

  // Only the receive-only slot lacks a transmit direction.
  function automatic logic slot_has_tx(input int unsigned slot,
                                       input int unsigned rx_only);
    return slot != rx_only;
  endfunction
endpackage

// File: rtl/dma_pair_route.sv
module dma_pair_route
  import dma_route_pkg::*;
#(
  parameter int unsigned SEL_W     = CODE_W,
  parameter int unsigned NUM_SLOTS = SLOTS,
  parameter int unsigned ADC_SLOT  = ADC_CODE,
  parameter int unsigned RSVD_SLOT = RSVD_CODE
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_SLOTS-1:0] rx_req,
  input  logic [NUM_SLOTS-1:0] tx_req,
  output logic [NUM_SLOTS-1:0] slot_hit,
  output logic                 even_req,
  output logic                 odd_req
);
  logic                 sel_ok;
  logic [NUM_SLOTS-1:0] tx_gated;

  assign sel_ok = code_routes(32'(sel), NUM_SLOTS, RSVD_SLOT);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_hit[s] = sel_ok && (sel == SEL_W'(s));
    if (slot_has_tx(s, ADC_SLOT)) begin : g_tx
      assign tx_gated[s] = tx_req[s];
    end else begin : g_no_tx
      assign tx_gated[s] = 1'b0;
    end
  end

  assign even_req = |(slot_hit & rx_req);
  assign odd_req  = |(slot_hit & tx_gated);
endmodule

// File: rtl/dma_ack_owner.sv
module dma_ack_owner
  import dma_route_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned NUM_SLOTS = SLOTS,
  parameter int unsigned ADC_SLOT  = ADC_CODE,
  localparam int unsigned NUM_CH   = 2 * NUM_PAIRS,
  localparam int unsigned HIT_W    = NUM_PAIRS * NUM_SLOTS
) (
  input  logic [HIT_W-1:0]     pair_hit,
  input  logic [NUM_CH-1:0]    ch_ack,
  output logic [HIT_W-1:0]     owner_hit,
  output logic [NUM_SLOTS-1:0] rx_ack,
  output logic [NUM_SLOTS-1:0] tx_ack
);
  always_comb begin
    owner_hit = '0;
    rx_ack    = '0;
    tx_ack    = '0;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      logic taken;
      taken = 1'b0;
      for (int p = 0; p < int'(NUM_PAIRS); p++) begin
        owner_hit[p*NUM_SLOTS+s] = pair_hit[p*NUM_SLOTS+s] && !taken;
        taken = taken | pair_hit[p*NUM_SLOTS+s];
        if (owner_hit[p*NUM_SLOTS+s]) begin
          rx_ack[s] = ch_ack[2*p];
          tx_ack[s] = ch_ack[2*p+1] && slot_has_tx(s, ADC_SLOT);
        end
      end
    end
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_pulse,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  output logic [NUM_CH-1:0] clr_eff,
  output logic [NUM_CH-1:0] status
);
  assign clr_eff = clr_we ? clr_mask : '0;

  // Set is OR-ed in after the clear so that a colliding set survives.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | set_pulse;
  end
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_route_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned SEL_W     = CODE_W,
  parameter int unsigned NUM_SLOTS = SLOTS,
  parameter int unsigned ADC_SLOT  = ADC_CODE,
  parameter int unsigned RSVD_SLOT = RSVD_CODE,
  localparam int unsigned NUM_CH   = 2 * NUM_PAIRS,
  localparam int unsigned HIT_W    = NUM_PAIRS * NUM_SLOTS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PAIRS*SEL_W-1:0] pair_sel,
  input  logic [NUM_SLOTS-1:0]       periph_rx_req,
  input  logic [NUM_SLOTS-1:0]       periph_tx_req,
  output logic [NUM_CH-1:0]          ch_req,
  input  logic [NUM_CH-1:0]          ch_ack,
  output logic [NUM_SLOTS-1:0]       periph_rx_ack,
  output logic [NUM_SLOTS-1:0]       periph_tx_ack,
  input  logic [NUM_CH-1:0]          irq_set,
  input  logic                       irq_clr_we,
  input  logic [NUM_CH-1:0]          irq_clr_data,
  output logic [NUM_CH-1:0]          irq_status
);
  logic [HIT_W-1:0]  pair_hit;
  logic [HIT_W-1:0]  owner_hit;
  logic [NUM_CH-1:0] clr_eff;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    dma_pair_route #(
      .SEL_W(SEL_W), .NUM_SLOTS(NUM_SLOTS),
      .ADC_SLOT(ADC_SLOT), .RSVD_SLOT(RSVD_SLOT)
    ) u_route (
      .sel     (pair_sel[p*SEL_W +: SEL_W]),
      .rx_req  (periph_rx_req),
      .tx_req  (periph_tx_req),
      .slot_hit(pair_hit[p*NUM_SLOTS +: NUM_SLOTS]),
      .even_req(ch_req[2*p]),
      .odd_req (ch_req[2*p+1])
    );
  end

  dma_ack_owner #(
    .NUM_PAIRS(NUM_PAIRS), .NUM_SLOTS(NUM_SLOTS), .ADC_SLOT(ADC_SLOT)
  ) u_owner (
    .pair_hit (pair_hit),
    .ch_ack   (ch_ack),
    .owner_hit(owner_hit),
    .rx_ack   (periph_rx_ack),
    .tx_ack   (periph_tx_ack)
  );

  dma_irq_status #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pulse(irq_set),
    .clr_we   (irq_clr_we),
    .clr_mask (irq_clr_data),
    .clr_eff  (clr_eff),
    .status   (irq_status)
  );
endmodule

// File: rtl/dma_req_router_chk.sv
module dma_req_router_chk
  import dma_route_pkg::*;
#(
  parameter int unsigned NUM_PAIRS = 2,
  parameter int unsigned SEL_W     = CODE_W,
  parameter int unsigned NUM_SLOTS = SLOTS,
  parameter int unsigned ADC_SLOT  = ADC_CODE,
  parameter int unsigned RSVD_SLOT = RSVD_CODE,
  localparam int unsigned NUM_CH   = 2 * NUM_PAIRS,
  localparam int unsigned HIT_W    = NUM_PAIRS * NUM_SLOTS
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PAIRS*SEL_W-1:0] pair_sel,
  input logic [NUM_CH-1:0]          ch_req,
  input logic [NUM_CH-1:0]          ch_ack,
  input logic [NUM_SLOTS-1:0]       periph_rx_ack,
  input logic [NUM_SLOTS-1:0]       periph_tx_ack,
  input logic [NUM_CH-1:0]          irq_set,
  input logic [NUM_CH-1:0]          clr_eff,
  input logic [NUM_CH-1:0]          irq_status,
  input logic [HIT_W-1:0]           owner_hit
);
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    AST_IDLE_PAIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !code_routes(32'(pair_sel[p*SEL_W +: SEL_W]), NUM_SLOTS, RSVD_SLOT)
        |-> (ch_req[2*p+1 -: 2] == 2'b00)); // R4
    AST_RX_ONLY_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_sel[p*SEL_W +: SEL_W] == SEL_W'(ADC_SLOT)) |-> !ch_req[2*p+1]); // R3
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      AST_OWNER_ACK_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_hit[p*NUM_SLOTS+s] && ch_ack[2*p]) |-> periph_rx_ack[s]); // R5
    end
  end

  AST_NO_ACK_WITHOUT_CH: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ack == '0) |-> (periph_rx_ack == '0 && periph_tx_ack == '0)); // R5
  AST_RX_ONLY_TX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_tx_ack[ADC_SLOT]); // R7

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[i] |=> irq_status[i]); // R10
    AST_CLEAR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_eff[i] && !irq_set[i]) |=> !irq_status[i]); // R9
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_eff[i] && !irq_set[i]) |=> $stable(irq_status[i])); // R11
  end
endmodule

bind dma_req_router dma_req_router_chk #(
  .NUM_PAIRS(NUM_PAIRS), .SEL_W(SEL_W), .NUM_SLOTS(NUM_SLOTS),
  .ADC_SLOT(ADC_SLOT), .RSVD_SLOT(RSVD_SLOT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pair_sel     (pair_sel),
  .ch_req       (ch_req),
  .ch_ack       (ch_ack),
  .periph_rx_ack(periph_rx_ack),
  .periph_tx_ack(periph_tx_ack),
  .irq_set      (irq_set),
  .clr_eff      (clr_eff),
  .irq_status   (irq_status),
  .owner_hit    (owner_hit)
);

// File: tb/sim_dma_req_router.sv
module sim_dma_req_router;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NC = 2 * NP;
  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4*NP-1:0] pair_sel = '1;
  logic [NS-1:0] rx_req = '0, tx_req = '0;
  logic [NC-1:0] ch_req, ch_ack = '0;
  logic [NS-1:0] rx_ack, tx_ack;
  logic [NC-1:0] irq_set = '0, irq_clr_data = '0, irq_status;
  logic          irq_clr_we = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_router u0 (
    .clk(clk), .rst_n(rst_n), .pair_sel(pair_sel),
    .periph_rx_req(rx_req), .periph_tx_req(tx_req), .ch_req(ch_req),
    .ch_ack(ch_ack), .periph_rx_ack(rx_ack), .periph_tx_ack(tx_ack),
    .irq_set(irq_set), .irq_clr_we(irq_clr_we),
    .irq_clr_data(irq_clr_data), .irq_status(irq_status)
  );

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference view: codes 0,2,3,4,5 route; 5 has no transmit side.
  function automatic bit routable(int c);
    return c == 0 || (c >= 2 && c <= 5);
  endfunction

  task automatic check_routing(string tag);
    logic [NC-1:0] e_req = '0;
    logic [NS-1:0] e_rx = '0, e_tx = '0;
    bit            claimed [NS];
    for (int s = 0; s < NS; s++) claimed[s] = 0;
    for (int p = 0; p < NP; p++) begin
      int c = int'(pair_sel[4*p +: 4]);
      if (routable(c)) begin
        e_req[2*p]   = rx_req[c];
        e_req[2*p+1] = (c != 5) && tx_req[c];
        if (!claimed[c]) begin
          claimed[c] = 1;
          e_rx[c] = ch_ack[2*p];
          e_tx[c] = (c != 5) && ch_ack[2*p+1];
        end
      end
    end
    #1;
    check_val({tag, " ch_req"}, 32'(ch_req), 32'(e_req));
    check_val({tag, " rx_ack"}, 32'(rx_ack), 32'(e_rx));
    check_val({tag, " tx_ack"}, 32'(tx_ack), 32'(e_tx));
  endtask

  task automatic apply(logic [3:0] s0, logic [3:0] s1, logic [NS-1:0] rx,
                       logic [NS-1:0] tx, logic [NC-1:0] ack, string tag);
    pair_sel = {s1, s0};
    rx_req = rx; tx_req = tx; ch_ack = ack;
    check_routing(tag);
  endtask

  task automatic t_reset();
    #1;
    check_val("R8 reset status", 32'(irq_status), 32'h0);
    check_val("R4 reset none sel req", 32'(ch_req), 32'h0);
  endtask

  task automatic t_single_pair();
    int codes [4] = '{0, 2, 3, 4};
    foreach (codes[k]) begin
      logic [3:0] c = 4'(codes[k]);
      apply(c, 4'hF, 6'h3F, 6'h00, 4'b0001, "R1 R5 pair0 rx");
      apply(c, 4'hF, 6'h00, 6'h3F, 4'b0010, "R2 R5 pair0 tx");
      apply(4'hF, c, 6'h15, 6'h2A, 4'b1100, "R1 R2 R5 pair1 mixed");
      apply(4'hF, c, 6'h2A, 6'h15, 4'b0100, "R1 R2 R5 pair1 swapped");
    end
    apply(4'h0, 4'h4, 6'h11, 6'h01, 4'b1111, "R1 R2 R5 two pairs");
  endtask

  task automatic t_adc();
    apply(4'h5, 4'hF, 6'h20, 6'h3F, 4'b0011, "R3 R7 adc pair0");
    check_val("R7 adc tx ack", 32'(tx_ack[5]), 32'h0);
    apply(4'hF, 4'h5, 6'h3F, 6'h3F, 4'b1111, "R3 R7 adc pair1");
    check_val("R3 adc odd req", 32'(ch_req[3]), 32'h0);
  endtask

  task automatic t_reserved();
    for (int c = 0; c < 16; c++) begin
      if (!routable(c)) begin
        apply(4'(c), 4'(c), 6'h3F, 6'h3F, 4'b1111, "R4 reserved or none");
        check_val("R4 acks silent", 32'({rx_ack, tx_ack}), 32'h0);
      end
    end
  endtask

  task automatic t_conflict();
    apply(4'h2, 4'h2, 6'h04, 6'h04, 4'b1100, "R6 upper pair ack dropped");
    check_val("R6 upper ack", 32'({rx_ack[2], tx_ack[2]}), 32'h0);
    apply(4'h2, 4'h2, 6'h04, 6'h00, 4'b0011, "R6 lower pair owns");
    check_val("R6 lower ack", 32'({rx_ack[2], tx_ack[2]}), 32'h3);
    apply(4'h4, 4'h4, 6'h00, 6'h10, 4'b1010, "R6 conflict tx");
  endtask

  task automatic irq_cycle(logic [NC-1:0] set, logic we, logic [NC-1:0] clr,
                           logic [NC-1:0] exp, string tag);
    @(negedge clk);
    irq_set = set; irq_clr_we = we; irq_clr_data = clr;
    @(negedge clk);
    irq_set = '0; irq_clr_we = 1'b0; irq_clr_data = '0;
    check_val(tag, 32'(irq_status), 32'(exp));
  endtask

  task automatic t_irq();
    irq_cycle(4'b0101, 1'b0, 4'b0000, 4'b0101, "R8 set pulses");
    irq_cycle(4'b0000, 1'b0, 4'b0000, 4'b0101, "R11 hold");
    irq_cycle(4'b0000, 1'b1, 4'b0000, 4'b0101, "R9 zero clear no effect");
    irq_cycle(4'b0000, 1'b0, 4'b0101, 4'b0101, "R9 mask without strobe");
    irq_cycle(4'b0000, 1'b1, 4'b0001, 4'b0100, "R9 clear one bit");
    irq_cycle(4'b0100, 1'b1, 4'b0100, 4'b0100, "R10 set wins");
    irq_cycle(4'b1010, 1'b1, 4'b0100, 4'b1010, "R8 R9 set and clear other");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single_pair();
    t_adc();
    t_reserved();
    t_conflict();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule